// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps three traffic statistics for a gigabit Ethernet MAC: the number of octets received, the number of octets transmitted and the number of frames received. The MAC sends it one event per finished frame, carrying the frame's byte count and its status flags. The block decides whether each event counts, adds the event to the right counters and never lets a counter wrap past its maximum.

Software reads the counters through a simple read port with word addresses. Each octet counter is 64 bits wide and is read as a low word and then a high word. Reading the high word returns the value the counter held at that moment and sets the counter to zero in the same cycle. The frame counter is one 32-bit word and is also cleared when it is read. The byte count supplied with a frame is expected to cover everything from the destination address through the CRC.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset, every readable word returns zero.
- R2: A read of address 0 returns receive octets [31:0], address 1 returns receive octets [63:32], address 2 returns transmit octets [31:0], address 3 returns transmit octets [63:32], address 4 returns the frame count, and addresses 5 to 7 return zero. The data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.
- R3: Reading address 1, 3 or 4 returns the counter value from before the read and clears that counter. Reading address 0 or 2 leaves the counter unchanged.
- R4: A counting event in the same cycle as a clearing read of its counter is added to zero, so the counter ends up holding only that event.
- R5: An octet addition that would go past all ones leaves the octet counter at all ones, and the counter stays there until it is cleared.
- R6: The frame counter stops at all ones and does not wrap.
- R7: When receive is enabled, a received frame adds `rx_len` to the receive octet counter and adds one to the frame counter, whatever the values of `rx_crc_err` and `rx_flow_ctl`.
- R8: A frame flagged `rx_rej_bcast` is counted, even if `rx_rej_other` is also set. A frame with only `rx_rej_other` set changes neither receive counter.
- R9: While `rx_en` is low, received frames change neither receive counter.
- R10: A transmitted frame adds `tx_len` to the transmit octet counter only when `tx_en` is high and `tx_abort` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Receive counting enable |
| tx_en | input | 1 | Transmit counting enable |
| rx_valid | input | 1 | One-cycle strobe for a finished receive frame |
| rx_len | input | LEN_W | Octets in the received frame, destination address through CRC |
| rx_crc_err | input | 1 | Frame had a CRC or other receive error, including a frame cut off by a link drop |
| rx_flow_ctl | input | 1 | Frame was a flow-control frame |
| rx_rej_bcast | input | 1 | Frame was rejected by the broadcast filter |
| rx_rej_other | input | 1 | Frame was rejected for any other reason |
| tx_valid | input | 1 | One-cycle strobe for a finished transmit frame |
| tx_len | input | LEN_W | Octets in the transmitted frame |
| tx_abort | input | 1 | Transmission was cut short, for example by a collision |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Word address |
| rd_data | output | 32 | Registered read data |

## Verification
A frame event that is strobed at a clock edge is in the counter right after that edge. A read issued at a later edge shows the value on `rd_data` one edge after its own strobe. A clearing read and an event at the same edge give the pre-clear value on `rd_data` at the next edge, and the next read then shows only that event. The bench's reference model steps at each rising edge, using the same inputs the design samples, and the bench compares `rd_data` with the model at every falling edge, so each read result is checked exactly one edge after its strobe. Saturation is reached with a narrowed instance (40-bit octet counters, 32-bit lengths, 8-bit frame counter), so that only a few hundred frames are needed.

// File: rtl/mac_stat_bank.sv
module mac_stat_bank #(
  parameter int OCT_W = 64,
  parameter int PKT_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_valid,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_crc_err,
  input  logic             rx_flow_ctl,
  input  logic             rx_rej_bcast,
  input  logic             rx_rej_other,
  input  logic             tx_valid,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             tx_abort,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  output logic [31:0]      rd_data
);

  logic [OCT_W-1:0] rx_oct, tx_oct;
  logic [PKT_W-1:0] pkt;
  logic [31:0]      rd_mux;

  logic unused_status;
  assign unused_status = rx_crc_err ^ rx_flow_ctl;

  function automatic logic [OCT_W-1:0] sat_add(input logic [OCT_W-1:0] base,
                                               input logic [LEN_W-1:0] len);
    logic [OCT_W:0] s;
    s = {1'b0, base} + (OCT_W+1)'(len);
    return s[OCT_W] ? '1 : s[OCT_W-1:0];
  endfunction

  wire rx_hit = rx_valid & rx_en & (rx_rej_bcast | ~rx_rej_other);
  wire tx_hit = tx_valid & tx_en & ~tx_abort;

  wire rx_clr  = rd_en && rd_addr == 3'd1;
  wire tx_clr  = rd_en && rd_addr == 3'd3;
  wire pkt_clr = rd_en && rd_addr == 3'd4;

  wire [OCT_W-1:0] rx_base  = rx_clr  ? '0 : rx_oct;
  wire [OCT_W-1:0] tx_base  = tx_clr  ? '0 : tx_oct;
  wire [PKT_W-1:0] pkt_base = pkt_clr ? '0 : pkt;

  always_comb begin
    case (rd_addr)
      3'd0:    rd_mux = rx_oct[31:0];
      3'd1:    rd_mux = 32'(rx_oct >> 32);
      3'd2:    rd_mux = tx_oct[31:0];
      3'd3:    rd_mux = 32'(tx_oct >> 32);
      3'd4:    rd_mux = 32'(pkt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_oct  <= '0;
      tx_oct  <= '0;
      pkt     <= '0;
      rd_data <= '0;
    end else begin
      rx_oct <= rx_hit ? sat_add(rx_base, rx_len) : rx_base;
      tx_oct <= tx_hit ? sat_add(tx_base, tx_len) : tx_base;
      pkt    <= (rx_hit && pkt_base != '1) ? pkt_base + 1'b1 : pkt_base;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

module mac_stat_bank_chk #(
  parameter int OCT_W = 64,
  parameter int PKT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_en,
  input logic             tx_en,
  input logic             tx_valid,
  input logic             tx_abort,
  input logic             rd_en,
  input logic [2:0]       rd_addr,
  input logic [31:0]      rd_data,
  input logic [OCT_W-1:0] rx_oct,
  input logic [OCT_W-1:0] tx_oct,
  input logic [PKT_W-1:0] pkt
);

  p_reset_zero_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (rx_oct == '0 && tx_oct == '0 && pkt == '0 && rd_data == '0));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_tx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 3'd3 && !(tx_valid && tx_en && !tx_abort)) |=> tx_oct == '0);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_oct == '1 && !(rd_en && rd_addr == 3'd1)) |=> rx_oct == '1);

  p_pkt_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == 3'd4) |=> pkt >= $past(pkt));

  p_rx_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !(rd_en && rd_addr == 3'd1)) |=> $stable(rx_oct));

endmodule

bind mac_stat_bank mac_stat_bank_chk #(.OCT_W(OCT_W), .PKT_W(PKT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
  .tx_valid(tx_valid), .tx_abort(tx_abort), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .rx_oct(rx_oct), .tx_oct(tx_oct), .pkt(pkt)
);

// File: tb/test_mac_stat_bank.sv
module test_mac_stat_bank;
  localparam int OCT_W = 40;
  localparam int PKT_W = 8;
  localparam int LEN_W = 32;
  localparam longint unsigned OMAX = (64'd1 << OCT_W) - 1;
  localparam int unsigned     PMAX = (1 << PKT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, tx_en = 0, rx_valid = 0, rx_crc_err = 0, rx_flow_ctl = 0;
  logic rx_rej_bcast = 0, rx_rej_other = 0, tx_valid = 0, tx_abort = 0, rd_en = 0;
  logic [LEN_W-1:0] rx_len = 0, tx_len = 0;
  logic [2:0] rd_addr = 0;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  mac_stat_bank #(.OCT_W(OCT_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) i_mac_stat_bank (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .rx_valid(rx_valid),
    .rx_len(rx_len), .rx_crc_err(rx_crc_err), .rx_flow_ctl(rx_flow_ctl),
    .rx_rej_bcast(rx_rej_bcast), .rx_rej_other(rx_rej_other), .tx_valid(tx_valid),
    .tx_len(tx_len), .tx_abort(tx_abort), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data));

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";
  longint unsigned m_rx = 0, m_tx = 0, n_rx, n_tx;
  int unsigned m_pk = 0, n_pk;
  logic [31:0] e_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_pk = 0; e_rd = 0;
    end else begin
      if (rd_en) begin
        case (rd_addr)
          3'd0: e_rd = m_rx[31:0];
          3'd1: e_rd = 32'(m_rx >> 32);
          3'd2: e_rd = m_tx[31:0];
          3'd3: e_rd = 32'(m_tx >> 32);
          3'd4: e_rd = m_pk;
          default: e_rd = 0;
        endcase
      end
      n_rx = (rd_en && rd_addr == 3'd1) ? 0 : m_rx;
      n_tx = (rd_en && rd_addr == 3'd3) ? 0 : m_tx;
      n_pk = (rd_en && rd_addr == 3'd4) ? 0 : m_pk;
      if (rx_valid && rx_en && (rx_rej_bcast || !rx_rej_other)) begin
        n_rx = n_rx + rx_len;
        if (n_rx > OMAX) n_rx = OMAX;
        if (n_pk < PMAX) n_pk++;
      end
      if (tx_valid && tx_en && !tx_abort) begin
        n_tx = n_tx + tx_len;
        if (n_tx > OMAX) n_tx = OMAX;
      end
      m_rx = n_rx; m_tx = n_tx; m_pk = n_pk;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (rd_data !== e_rd) begin
        errors++;
        $display("FAIL %s rd_data=%h expected=%h", tag, rd_data, e_rd);
      end
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic tick();
    @(negedge clk);
    rx_valid = 0; tx_valid = 0; rd_en = 0;
    rx_crc_err = 0; rx_flow_ctl = 0; rx_rej_bcast = 0; rx_rej_other = 0; tx_abort = 0;
  endtask

  task automatic set_rx(input logic [31:0] len, input logic crc, input logic fc,
                        input logic bc, input logic oth);
    rx_valid = 1; rx_len = len; rx_crc_err = crc; rx_flow_ctl = fc;
    rx_rej_bcast = bc; rx_rej_other = oth;
  endtask

  task automatic set_tx(input logic [31:0] len, input logic ab);
    tx_valid = 1; tx_len = len; tx_abort = ab;
  endtask

  task automatic set_rd(input logic [2:0] a);
    rd_en = 1; rd_addr = a;
  endtask

  task automatic rd(input logic [2:0] a);
    set_rd(a); tick(); tick();
  endtask

  initial begin
    tick(); tick();
    rst_n = 1;
    tag = "R1";
    for (int a = 0; a < 5; a++) rd(3'(a));
    rx_en = 1; tx_en = 1;

    tag = "R7";
    set_rx(64, 0, 0, 0, 0); tick();
    set_rx(1518, 1, 0, 0, 0); tick();
    set_rx(64, 0, 1, 0, 0); tick();
    set_rx(300, 1, 1, 0, 0); tick();
    rd(0); rd(4);

    tag = "R8";
    set_rx(100, 0, 0, 1, 0); tick();
    set_rx(200, 0, 0, 0, 1); tick();
    rd(0); rd(4);
    set_rx(50, 0, 0, 1, 1); tick();
    rd(0); rd(4);

    tag = "R9";
    rx_en = 0;
    set_rx(500, 0, 0, 0, 0); tick();
    set_rx(70, 0, 0, 1, 0); tick();
    rd(0); rd(4);
    rx_en = 1;

    tag = "R10";
    set_tx(1000, 0); tick();
    set_tx(400, 1); tick();
    rd(2);
    tx_en = 0;
    set_tx(80, 0); tick();
    rd(2);
    tx_en = 1;
    set_tx(32'hFFFF_FFFF, 0); tick();
    set_tx(32'hFFFF_FFFF, 0); tick();
    rd(2); rd(3);

    tag = "R3";
    rd(0); rd(0); rd(1); rd(0); rd(1);
    rd(2); rd(3); rd(2); rd(3);

    tag = "R4";
    set_rx(77, 0, 0, 0, 0); tick();
    set_rx(33, 0, 0, 0, 0); set_rd(1); tick(); tick();
    rd(0);
    set_tx(55, 0); set_rd(3); tick(); tick();
    rd(2);
    set_rx(10, 0, 0, 0, 0); set_rd(4); tick(); tick();
    rd(4);

    tag = "R2";
    rd(5); rd(6); rd(7);
    for (int i = 0; i < 4; i++) tick();

    tag = "R5";
    for (int i = 0; i < 300; i++) begin set_rx(32'hFFFF_FFFF, 0, 0, 0, 0); tick(); end
    rd(0); rd(1); rd(0);
    tag = "R6";
    for (int i = 0; i < 300; i++) begin set_rx(1, 0, 0, 0, 0); tick(); end
    rd(4); rd(4);
    tag = "R5";
    for (int i = 0; i < 300; i++) begin set_tx(32'hFFFF_FFFF, 0); tick(); end
    rd(2); rd(3); rd(2);

    tick();
    summary();
  end
endmodule